// File: doc/BRIEF.md
# Bit-Serial Depth-Buffered Pixel Processor Array

This block is a small grid of pixel processors, one per screen location, that rasterises convex polygons without ever walking their area. A controller receives a command and then a stream of coefficient bits, least significant bit first. Two chains of one-bit serial adders turn the A, B and C bits into one stream per column (A·x + C) and one stream per row (B·y). Every cell adds its column stream to its row stream with a one-bit adder, so each cell sees its own value of F = A·x + B·y + C one bit per beat. All cells see it in the same beats.

One polygon is drawn as a fixed series of passes. A start command enables every cell. One edge pass per polygon edge clears the cells lying on the negative side of that edge. A depth pass then compares F with each cell's stored depth using a one-bit serial comparator. Three shade passes write the red, green and blue values into the back image buffer. A swap command then makes that buffer the visible one. Each pass costs the same number of beats whatever the polygon covers, so the drawing time depends only on the edge count.

Command and coefficient transfers are valid/ready handshakes. A command is taken only when `cmd_valid` and `cmd_ready` are both high. A coefficient beat is taken only when `bit_valid` and `bit_ready` are both high. The sender may hold `bit_valid` low for any number of cycles inside a pass, and the pass simply waits. `cmd_ready` stays low from the acceptance of a pass command until its final beat is taken. `bit_ready` is high exactly in that window. The read port is plain combinational selection with no handshake.

Top module: `pp_array`

## Requirements
- R1: After reset every enable flag is 0, every depth register holds all ones (0xFFFF), both image buffers hold 0, `cmd_ready` is 1 and `bit_ready` is 0.
- R2: A command is accepted on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is high only while no pass is in progress. The command codes on `cmd_op` are 0 = start, 1 = edge pass, 2 = depth pass, 3 = shade pass and 4 = swap. Codes 5 to 7 change no state.
- R3: After a pass command is accepted, `bit_ready` is 1 until the pass's last beat is taken, and it is never high together with `cmd_ready`. Each beat carries one bit of A, B and C, least significant bit first. Edge and depth passes take 16 beats and shade passes take 8. Input values in cycles without a beat have no effect.
- R4: In a pass of L beats, the cell at column x and row y evaluates F = (A·x + B·y + C) mod 2^L. The cell index on the read port is y·COLS + x.
- R5: A start command sets the enable flag of every cell.
- R6: At the end of an edge pass, a cell whose F has bit 15 set clears its enable flag. All other flags keep their value.
- R7: At the end of a depth pass, an enabled cell with F below its stored depth (unsigned, strict) loads F as its new depth and stays enabled. Every other cell clears its flag and keeps its depth. So a depth never increases.
- R8: At the end of a shade pass with channel `cmd_chan` equal to 0, 1 or 2, each enabled cell writes the 8-bit F into that channel of its back buffer. Channel 3, disabled cells and the front buffer are left unchanged.
- R9: A swap command exchanges the front and back buffers. `rd_color` shows the front buffer as {channel 2, channel 1, channel 0}, with channel 0 in bits 7:0.
- R10: `done` is a one-cycle pulse in the cycle after a pass's last beat, or in the cycle after any non-pass command (codes 0, 4, 5, 6, 7) is accepted.
- R11: `rd_en`, `rd_depth` and `rd_color` show the cell chosen by `rd_x` and `rd_y` in the same cycle. The stored state changes only in the cycle that raises `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (no pass active) |
| cmd_op | input | 3 | Command code |
| cmd_chan | input | 2 | Colour channel for a shade pass |
| bit_valid | input | 1 | Coefficient beat offered |
| bit_ready | output | 1 | Pass in progress, beat can be taken |
| coef_a | input | 1 | Serial bit of A |
| coef_b | input | 1 | Serial bit of B |
| coef_c | input | 1 | Serial bit of C |
| done | output | 1 | One-cycle command completion pulse |
| rd_x | input | 2 | Read column |
| rd_y | input | 2 | Read row |
| rd_en | output | 1 | Enable flag of the selected cell |
| rd_depth | output | 16 | Stored depth of the selected cell |
| rd_color | output | 24 | Front-buffer colour of the selected cell |

## Verification
The bench stalls the coefficient stream at random points inside passes and drives junk bits while stalled. A design that let carries or comparator state advance without a beat would then produce wrong F values. It replays a depth that equals the stored one to catch a design that treats equality as a win. It uses negative coefficients so that an edge test reading the wrong sign bit would enable the wrong cells. Shades to channel 3, unused opcodes and a double swap check that nothing leaks into the image, and that the front buffer is never written while a pass fills the back one.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int NCH = 3;

  typedef enum logic [2:0] {
    OP_START = 3'd0,
    OP_EDGE  = 3'd1,
    OP_DEPTH = 3'd2,
    OP_SHADE = 3'd3,
    OP_SWAP  = 3'd4
  } pp_op_e;
endpackage

// File: rtl/pp_sgen.sv
// Chain of one-bit serial adders: lane k carries base + k*inc, bit-serially.
module pp_sgen #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic         base_bit,
  input  logic         inc_bit,
  output logic [N-1:0] lane
);
  logic [N-1:0] cy_q;
  logic [N-1:0] cy_d;

  always_comb begin
    logic t;
    t       = base_bit;
    lane[0] = t;
    cy_d    = '0;
    for (int k = 1; k < N; k++) begin
      cy_d[k] = (t & inc_bit) | (t & cy_q[k]) | (inc_bit & cy_q[k]);
      t       = t ^ inc_bit ^ cy_q[k];
      lane[k] = t;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cy_q <= '0;
    else if (clr)  cy_q <= '0;
    else if (step) cy_q <= cy_d;
  end
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pp_pkg::*;
#(
  parameter int ZW = 16,
  parameter int CW = 8,
  localparam int IW = $clog2(ZW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [1:0]    cmd_chan,
  input  logic          bit_valid,
  output logic          bit_ready,
  output logic          clr,
  output logic          step,
  output logic          last,
  output logic          start_p,
  output pp_op_e        op_q,
  output logic [1:0]    chan_q,
  output logic          sel_q,
  output logic [IW-1:0] idx,
  output logic          done
);
  logic          active_q;
  logic [IW-1:0] cnt_q;
  logic          accept;
  logic          pass_cmd;
  logic [IW-1:0] last_idx;

  assign cmd_ready = ~active_q;
  assign bit_ready = active_q;
  assign accept    = cmd_valid & ~active_q;
  assign pass_cmd  = (cmd_op == OP_EDGE) || (cmd_op == OP_DEPTH) || (cmd_op == OP_SHADE);
  assign clr       = accept & pass_cmd;
  assign start_p   = accept & (cmd_op == OP_START);
  assign step      = active_q & bit_valid;
  assign last_idx  = (op_q == OP_SHADE) ? IW'(CW - 1) : IW'(ZW - 1);
  assign last      = step & (cnt_q == last_idx);
  assign idx       = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      op_q     <= OP_START;
      chan_q   <= '0;
      sel_q    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (pass_cmd) begin
          active_q <= 1'b1;
          cnt_q    <= '0;
          op_q     <= pp_op_e'(cmd_op);
          chan_q   <= cmd_chan;
        end else begin
          done <= 1'b1;
          if (cmd_op == OP_SWAP) sel_q <= ~sel_q;
        end
      end
      if (step) begin
        if (last) begin
          active_q <= 1'b0;
          done     <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pp_cell.sv
module pp_cell
  import pp_pkg::*;
#(
  parameter int ZW = 16,
  parameter int CW = 8,
  localparam int IW = $clog2(ZW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic          last,
  input  logic          start_p,
  input  pp_op_e        op,
  input  logic [1:0]    chan,
  input  logic          cur_sel,
  input  logic [IW-1:0] idx,
  input  logic          xs,
  input  logic          ys,
  output logic          en_o,
  output logic [ZW-1:0] depth_o,
  output logic [NCH*CW-1:0] color_o
);
  logic          cy_q, lt_q, en_q;
  logic [ZW-1:0] f_sr, depth_q;
  logic [CW-1:0] img [2][NCH];
  logic          sum, cy_n, dbit, lt_n;
  logic [ZW-1:0] f_next;

  // one-bit adder and one-bit running less-than comparator
  assign sum    = xs ^ ys ^ cy_q;
  assign cy_n   = (xs & ys) | (xs & cy_q) | (ys & cy_q);
  assign dbit   = depth_q[idx];
  assign lt_n   = (~sum & dbit) | (~(sum ^ dbit) & lt_q);
  assign f_next = {sum, f_sr[ZW-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cy_q    <= 1'b0;
      lt_q    <= 1'b0;
      en_q    <= 1'b0;
      f_sr    <= '0;
      depth_q <= '1;
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < NCH; c++) img[b][c] <= '0;
    end else begin
      if (clr) begin
        cy_q <= 1'b0;
        lt_q <= 1'b0;
      end
      if (start_p) en_q <= 1'b1;
      if (step) begin
        cy_q <= cy_n;
        lt_q <= lt_n;
        f_sr <= f_next;
        if (last) begin
          case (op)
            OP_EDGE:  if (sum) en_q <= 1'b0;
            OP_DEPTH: if (en_q && lt_n) depth_q <= f_next;
                      else en_q <= 1'b0;
            OP_SHADE: if (en_q && (32'(chan) < NCH)) img[~cur_sel][chan] <= f_next[ZW-1 -: CW];
            default: ;
          endcase
        end
      end
    end
  end

  assign en_o    = en_q;
  assign depth_o = depth_q;
  assign color_o = {img[cur_sel][2], img[cur_sel][1], img[cur_sel][0]};
endmodule

// File: rtl/pp_array.sv
module pp_array
  import pp_pkg::*;
#(
  parameter int COLS = 4,
  parameter int ROWS = 4,
  parameter int ZW   = 16,
  parameter int CW   = 8,
  localparam int XW    = $clog2(COLS),
  localparam int YW    = $clog2(ROWS),
  localparam int IW    = $clog2(ZW),
  localparam int CELLS = COLS * ROWS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [1:0]        cmd_chan,
  input  logic              bit_valid,
  output logic              bit_ready,
  input  logic              coef_a,
  input  logic              coef_b,
  input  logic              coef_c,
  output logic              done,
  input  logic [XW-1:0]     rd_x,
  input  logic [YW-1:0]     rd_y,
  output logic              rd_en,
  output logic [ZW-1:0]     rd_depth,
  output logic [NCH*CW-1:0] rd_color
);
  logic          clr, step, last, start_p, sel_q;
  pp_op_e        op_q;
  logic [1:0]    chan_q;
  logic [IW-1:0] idx;
  logic [COLS-1:0] xs;
  logic [ROWS-1:0] ys;

  logic [CELLS-1:0]        en_flat;
  logic [CELLS*ZW-1:0]     depth_flat;
  logic [CELLS*NCH*CW-1:0] color_flat;

  pp_ctrl #(.ZW(ZW), .CW(CW)) u_ctrl (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_op, .cmd_chan,
    .bit_valid, .bit_ready, .clr, .step, .last, .start_p,
    .op_q, .chan_q, .sel_q, .idx, .done
  );

  pp_sgen #(.N(COLS)) u_xgen (
    .clk, .rst_n, .clr, .step, .base_bit(coef_c), .inc_bit(coef_a), .lane(xs)
  );

  pp_sgen #(.N(ROWS)) u_ygen (
    .clk, .rst_n, .clr, .step, .base_bit(1'b0), .inc_bit(coef_b), .lane(ys)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int I = r * COLS + c;
      pp_cell #(.ZW(ZW), .CW(CW)) u_cell (
        .clk, .rst_n, .clr, .step, .last, .start_p,
        .op(op_q), .chan(chan_q), .cur_sel(sel_q), .idx,
        .xs(xs[c]), .ys(ys[r]),
        .en_o(en_flat[I]),
        .depth_o(depth_flat[I*ZW +: ZW]),
        .color_o(color_flat[I*NCH*CW +: NCH*CW])
      );
    end
  end

  always_comb begin
    rd_en    = 1'b0;
    rd_depth = '0;
    rd_color = '0;
    for (int i = 0; i < CELLS; i++) begin
      if ((32'(rd_y) * COLS + 32'(rd_x)) == i) begin
        rd_en    = en_flat[i];
        rd_depth = depth_flat[i*ZW +: ZW];
        rd_color = color_flat[i*NCH*CW +: NCH*CW];
      end
    end
  end
endmodule

// File: rtl/pp_array_chk.sv
module pp_array_chk #(
  parameter int CELLS = 16,
  parameter int ZW    = 16,
  parameter int CW    = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic                  cmd_ready,
  input logic [2:0]            cmd_op,
  input logic                  bit_valid,
  input logic                  bit_ready,
  input logic                  done,
  input logic [CELLS-1:0]      en_flat,
  input logic [CELLS*ZW-1:0]   depth_flat,
  input logic [CELLS*3*CW-1:0] color_flat
);
  p_ready_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ready && bit_ready));

  p_pass_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_op == 3'd1 || cmd_op == 3'd2 || cmd_op == 3'd3))
      |=> (bit_ready && !cmd_ready));

  p_done_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(bit_valid && bit_ready) || $past(cmd_valid && cmd_ready)));

  p_quiet_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(en_flat) && $stable(depth_flat) && $stable(color_flat)));

  for (genvar i = 0; i < CELLS; i++) begin : g_mono
    p_depth_nonincr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      depth_flat[i*ZW +: ZW] <= $past(depth_flat[i*ZW +: ZW]));
  end
endmodule

bind pp_array pp_array_chk #(.CELLS(CELLS), .ZW(ZW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .bit_valid(bit_valid), .bit_ready(bit_ready), .done(done),
  .en_flat(en_flat), .depth_flat(depth_flat), .color_flat(color_flat)
);

// File: tb/pp_array_tb.sv
module pp_array_tb;
  localparam int COLS = 4, ROWS = 4, ZW = 16, CW = 8, CELLS = COLS * ROWS;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cmd_valid, cmd_ready, bit_valid, bit_ready;
  logic coef_a, coef_b, coef_c, done, rd_en;
  logic [2:0] cmd_op;
  logic [1:0] cmd_chan, rd_x, rd_y;
  logic [ZW-1:0] rd_depth;
  logic [23:0] rd_color;

  pp_array #(.COLS(COLS), .ROWS(ROWS), .ZW(ZW), .CW(CW)) u_dut (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_op, .cmd_chan,
    .bit_valid, .bit_ready, .coef_a, .coef_b, .coef_c, .done,
    .rd_x, .rd_y, .rd_en, .rd_depth, .rd_color
  );

  int n_chk = 0, n_bad = 0;
  string rd_tag = "R1";
  bit finished = 0;

  // behavioural reference
  bit          m_en [CELLS];
  int unsigned m_depth [CELLS];
  int unsigned m_img [2][CELLS];
  bit          m_sel, m_active, m_done;
  int          m_cnt, m_op, m_chan;
  int unsigned m_a, m_b, m_c;

  function automatic int unsigned f_of(int i, int len);
    int unsigned x = i % COLS, y = i / COLS;
    return (m_a * x + m_b * y + m_c) & ((32'd1 << len) - 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CELLS; i++) begin
        m_en[i] = 0; m_depth[i] = 32'hFFFF; m_img[0][i] = 0; m_img[1][i] = 0;
      end
      m_sel = 0; m_active = 0; m_done = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (!m_active) begin
        if (cmd_valid) begin
          if (cmd_op >= 3'd1 && cmd_op <= 3'd3) begin
            m_active = 1; m_cnt = 0; m_op = int'(cmd_op); m_chan = int'(cmd_chan);
            m_a = 0; m_b = 0; m_c = 0;
          end else begin
            m_done = 1;
            if (cmd_op == 3'd0) for (int i = 0; i < CELLS; i++) m_en[i] = 1;
            if (cmd_op == 3'd4) m_sel = ~m_sel;
          end
        end
      end else if (bit_valid) begin
        int len;
        len = (m_op == 3) ? CW : ZW;
        m_a |= int'(coef_a) << m_cnt;
        m_b |= int'(coef_b) << m_cnt;
        m_c |= int'(coef_c) << m_cnt;
        if (m_cnt == len - 1) begin
          for (int i = 0; i < CELLS; i++) begin
            int unsigned f;
            f = f_of(i, len);
            if (m_op == 1) begin
              if (f[15]) m_en[i] = 0;
            end else if (m_op == 2) begin
              if (m_en[i] && f < m_depth[i]) m_depth[i] = f;
              else m_en[i] = 0;
            end else if (m_chan < 3 && m_en[i]) begin
              m_img[!m_sel][i] = (m_img[!m_sel][i] & ~(32'hFF << (8 * m_chan))) | (f << (8 * m_chan));
            end
          end
          m_active = 0; m_done = 1;
        end else m_cnt++;
      end
    end
  end

  task automatic check(bit ok, string tag, int unsigned got, int unsigned exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  // compare every clock, then step the read address
  always @(negedge clk) begin
    if (!finished) begin
      int i;
      i = int'(rd_y) * COLS + int'(rd_x);
      check(cmd_ready == !m_active, "R2 cmd_ready", cmd_ready, !m_active);
      check(bit_ready == m_active, "R3 bit_ready", bit_ready, m_active);
      check(done == m_done, "R10 done", done, m_done);
      check(rd_en == m_en[i], {rd_tag, " R5 R6 R7 R11 rd_en"}, rd_en, m_en[i]);
      check(rd_depth == m_depth[i][15:0], {rd_tag, " R4 R7 R11 rd_depth"}, rd_depth, m_depth[i]);
      check(rd_color == m_img[m_sel][i][23:0], {rd_tag, " R4 R8 R9 R11 rd_color"}, rd_color, m_img[m_sel][i]);
      {rd_y, rd_x} <= {rd_y, rd_x} + 4'd1;
    end
  end

  task automatic summary();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !finished) begin
      n_bad++;
      summary();
    end
  end

  task automatic send_cmd(logic [2:0] op, logic [1:0] ch);
    @(negedge clk); #2;
    cmd_valid = 1; cmd_op = op; cmd_chan = ch;
    @(negedge clk); #2;
    cmd_valid = 0; cmd_op = $urandom_range(0, 7); cmd_chan = $urandom_range(0, 3);
  endtask

  task automatic send_pass(logic [2:0] op, logic [1:0] ch, logic [15:0] a, logic [15:0] b, logic [15:0] c);
    int len, i;
    send_cmd(op, ch);
    len = (op == 3'd3) ? CW : ZW;
    i = 0;
    while (i < len) begin
      if ($urandom_range(0, 3) == 0) begin   // stall with junk bits (R3)
        bit_valid = 0;
        coef_a = $urandom_range(0, 1); coef_b = $urandom_range(0, 1); coef_c = $urandom_range(0, 1);
      end else begin
        bit_valid = 1; coef_a = a[i]; coef_b = b[i]; coef_c = c[i];
        i++;
      end
      @(negedge clk); #2;
    end
    bit_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_chan = 0; bit_valid = 0;
    coef_a = 0; coef_b = 0; coef_c = 0; rd_x = 0; rd_y = 0;
    repeat (3) @(negedge clk);
    #2 rst_n = 1;
    repeat (20) @(negedge clk);   // R1: reset state swept over all cells
    rd_tag = "R9";

    // fill every cell then show it (R5 R8 R9)
    send_cmd(3'd0, 0);
    send_pass(3'd3, 0, 16'd10, 16'd3, 16'd7);
    send_cmd(3'd4, 0);
    repeat (20) @(negedge clk);

    // polygon 1: edges x>=1, x<=3, y>=x-1 (R6), depth x+y+5 (R7)
    send_cmd(3'd0, 0);
    send_pass(3'd1, 0, 16'd1, 16'd0, 16'hFFFF);
    send_pass(3'd1, 0, 16'hFFFF, 16'd0, 16'd3);
    send_pass(3'd1, 0, 16'hFFFF, 16'd1, 16'd1);
    send_pass(3'd2, 0, 16'd1, 16'd1, 16'd5);
    send_pass(3'd3, 0, 16'd9, 16'd17, 16'd2);
    send_pass(3'd3, 1, 16'hF0, 16'd1, 16'd40);
    send_pass(3'd3, 2, 16'd0, 16'hFE, 16'd200);
    repeat (20) @(negedge clk);   // R8: front buffer untouched until swap
    send_cmd(3'd4, 0);
    repeat (20) @(negedge clk);

    // polygon 2: y<=2, depth 20-3x (R7 partial wins)
    send_cmd(3'd0, 0);
    send_pass(3'd1, 0, 16'd0, 16'hFFFF, 16'd2);
    send_pass(3'd2, 0, 16'hFFFD, 16'd0, 16'd20);
    send_pass(3'd3, 0, 16'd1, 16'd1, 16'd1);
    send_pass(3'd3, 3, 16'd5, 16'd5, 16'd5);   // channel 3 ignored (R8)
    send_cmd(3'd4, 0);
    repeat (20) @(negedge clk);

    // equal depth must lose (R7), unused opcodes (R2), double swap (R9)
    send_cmd(3'd0, 0);
    send_pass(3'd2, 0, 16'd1, 16'd1, 16'd5);
    send_pass(3'd3, 1, 16'd3, 16'd3, 16'd3);
    send_cmd(3'd7, 0);
    send_cmd(3'd5, 2);
    send_cmd(3'd6, 1);
    send_cmd(3'd4, 0);
    send_cmd(3'd4, 0);
    repeat (20) @(negedge clk);
    send_cmd(3'd4, 0);
    repeat (20) @(negedge clk);
    summary();
  end
endmodule